// File: doc/BRIEF.md
# Ping-Pong Bitstream Buffer Manager

This controller governs a bitstream buffer made of two banks. It has two kinds of mode. In a static mode, each bank is tied to one bus master: the coprocessor bus, the DMA, or the codec engine. In an automatic mode, the two banks alternate between the codec engine and the DMA. While the codec works on one bank, the DMA moves the other bank to or from memory in chunks of a chosen size. The memory arrays and the DMA engine are outside this block.

The codec reports a finished bank with a one-cycle `fill_done` pulse. In encode mode this means the bank is full; in decode mode it means the bank has been drained. That bank then passes to the DMA side. The block asks for chunks over a valid/ready request channel. The DMA reports each finished chunk with a `dma_xfer_done` pulse. After the last chunk of a bank, the bank returns to the codec.

Back-pressure works as follows. Once `dma_req_valid` is raised, it stays high, with `dma_req_bank` and `dma_req_bytes` unchanged, until a cycle in which `dma_req_ready` is high. Only one chunk is ever outstanding at a time. A mode change is the only thing that withdraws a raised request.

Top module: `bsm_pingpong_mgr`

## Requirements
- R1: Bank owners use the code 0 = coprocessor bus, 1 = DMA, 2 = codec. `bank_owner[1:0]` is bank 0 and `bank_owner[3:2]` is bank 1. The static modes map owners as follows:
  - mode 0: both banks to the coprocessor bus.
  - mode 1: both banks to the DMA.
  - mode 2: both banks to the codec.
  - mode 3: bank 0 to the DMA, bank 1 to the codec.
  - mode 4: bank 0 to the codec, bank 1 to the DMA.
  - mode 7: same as mode 0.
  
  Owners follow a mode change one cycle later.
- R2: In any static mode, `busy` is 0 and no DMA request is raised.
- R3: Entering mode 5 (encode) or mode 6 (decode) sets `busy`. Encode starts with both banks owned by the codec. Decode starts with both banks owned by the DMA.
- R4: A `fill_done` pulse for a bank owned by the codec hands that bank to the DMA one cycle later.
- R5: The transfer-size code s gives chunks of 2048 >> s bytes, shown on `dma_req_bytes`. One bank takes BANK_BYTES / chunk bytes chunks (1, 2, 4 or 8 by default). The bank returns to the codec on the edge that sees the done pulse of its last chunk.
- R6: Banks are served by the DMA in strict alternation, starting with bank 0. A bank that is waiting out of turn gets no request.
- R7: A raised request holds its bank and byte count until it is accepted. A `dma_xfer_done` pulse that arrives while no chunk is outstanding is ignored.
- R8: The transfer size is sampled when the first chunk of a bank is requested. Changing it in the middle of a bank affects only the next bank.
- R9: In encode mode, a `stream_end` pulse is followed by `busy` falling once both banks are owned by the codec and no request is raised. In decode mode, `busy` stays set until the mode changes.
- R10: Any mode change discards the bank sequence: bank states, the served-bank pointer, the chunk count, any raised or outstanding request, and the end flag.
- R11: The final chunk completion of one bank and a codec hand-off of the other bank in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Buffer mode code |
| xfer_size | input | 2 | Chunk size code (automatic modes only) |
| fill_done | input | 2 | Per-bank codec completion pulse |
| stream_end | input | 1 | Codec finished the stream (encode) |
| dma_req_ready | input | 1 | DMA accepts the raised request |
| dma_xfer_done | input | 1 | DMA finished the outstanding chunk |
| bank_owner | output | 4 | Owner code per bank |
| dma_req_valid | output | 1 | Chunk request raised |
| dma_req_bank | output | 1 | Bank of the raised request |
| dma_req_bytes | output | 12 | Byte count of the raised request |
| busy | output | 1 | Automatic sequencing in progress |

## Verification
Two events can fall on the same clock edge:
- the DMA completing the last chunk of one bank, which returns that bank to the codec;
- the codec handing over the other bank.

The bench provokes this in encode mode. With a single chunk per bank, it holds the chunk of bank 0 outstanding, then pulses `dma_xfer_done` together with `fill_done[1]`. It judges the result from both owner fields one cycle later, and from the next request naming bank 1. A second collision pairs a mode change with an outstanding chunk. There, the bench expects the fresh sequence to start again at bank 0.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int NUM_BANKS = 2;

  typedef enum logic [1:0] {
    OWN_COPRO = 2'd0,
    OWN_DMA   = 2'd1,
    OWN_CODEC = 2'd2
  } owner_e;

  localparam logic [2:0] MODE_ENC = 3'd5;
  localparam logic [2:0] MODE_DEC = 3'd6;

  function automatic logic is_auto(input logic [2:0] m);
    return (m == MODE_ENC) || (m == MODE_DEC);
  endfunction

  // static owner map; b is the bank index
  function automatic owner_e static_owner(input logic [2:0] m, input logic b);
    case (m)
      3'd1:    return OWN_DMA;
      3'd2:    return OWN_CODEC;
      3'd3:    return b ? OWN_CODEC : OWN_DMA;
      3'd4:    return b ? OWN_DMA : OWN_CODEC;
      default: return OWN_COPRO;
    endcase
  endfunction
endpackage

// File: rtl/bsm_bank_ctrl.sv
module bsm_bank_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic start_on_dma,
  input  logic auto_en,
  input  logic fill_done,
  input  logic release_i,
  output logic on_dma
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           on_dma <= 1'b0;
    else if (restart)                     on_dma <= start_on_dma;
    else if (auto_en) begin
      if (!on_dma && fill_done)           on_dma <= 1'b1;
      else if (on_dma && release_i)       on_dma <= 1'b0;
    end
  end

  // R5: a bank leaves the DMA side only on its final chunk or a restart
  p_release_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(on_dma) |-> $past(release_i || restart));
  // R4: a bank reaches the DMA side only through a codec hand-off or restart
  p_handoff_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_dma) |-> $past(fill_done || restart));
endmodule

// File: rtl/bsm_dma_seq.sv
module bsm_dma_seq #(
  parameter int BANK_BYTES     = 2048,
  parameter int MAX_XFER_BYTES = 2048
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              restart,
  input  logic                              auto_en,
  input  logic [1:0]                        xfer_size,
  input  logic [bsm_pkg::NUM_BANKS-1:0]     bank_on_dma,
  input  logic                              req_ready,
  input  logic                              xfer_done,
  output logic                              req_valid,
  output logic                              req_bank,
  output logic [$clog2(MAX_XFER_BYTES):0]   req_bytes,
  output logic [bsm_pkg::NUM_BANKS-1:0]     bank_release,
  output logic                              active
);
  localparam int BASE_CHUNKS = BANK_BYTES / MAX_XFER_BYTES;
  localparam int CNT_W       = $clog2(BASE_CHUNKS * 8) + 1;
  localparam int BYTES_W     = $clog2(MAX_XFER_BYTES) + 1;

  logic             ptr, outst;
  logic [1:0]       size_q;
  logic [CNT_W-1:0] cnt, last_idx;
  logic             finish, is_last;

  assign last_idx  = CNT_W'((BASE_CHUNKS << size_q) - 1);
  assign finish    = outst && xfer_done;
  assign is_last   = (cnt == last_idx);
  assign req_bank  = ptr;
  assign req_bytes = BYTES_W'(MAX_XFER_BYTES >> size_q);
  assign active    = req_valid || outst;

  always_comb begin
    bank_release = '0;
    if (finish && is_last && !restart) bank_release[ptr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= 1'b0; outst <= 1'b0; req_valid <= 1'b0; cnt <= '0; size_q <= '0;
    end else if (restart) begin
      ptr <= 1'b0; outst <= 1'b0; req_valid <= 1'b0; cnt <= '0;
    end else if (auto_en) begin
      if (!req_valid && !outst && bank_on_dma[ptr]) begin
        req_valid <= 1'b1;
        if (cnt == '0) size_q <= xfer_size;
      end
      if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        outst     <= 1'b1;
      end
      if (finish) begin
        outst <= 1'b0;
        if (is_last) begin
          cnt <= '0;
          ptr <= ~ptr;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7: a raised request waits, unchanged, for ready
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !restart) |=> (req_valid && $stable(req_bank) && $stable(req_bytes)));
  // R6: a request only names a bank that sits on the DMA side
  p_req_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> bank_on_dma[req_bank]);
  // R5: chunk count never passes the per-bank total
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_idx);
endmodule

// File: rtl/bsm_pingpong_mgr.sv
module bsm_pingpong_mgr #(
  parameter int BANK_BYTES     = 2048,
  parameter int MAX_XFER_BYTES = 2048
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [2:0]                       mode,
  input  logic [1:0]                       xfer_size,
  input  logic [1:0]                       fill_done,
  input  logic                             stream_end,
  input  logic                             dma_req_ready,
  input  logic                             dma_xfer_done,
  output logic [3:0]                       bank_owner,
  output logic                             dma_req_valid,
  output logic                             dma_req_bank,
  output logic [$clog2(MAX_XFER_BYTES):0]  dma_req_bytes,
  output logic                             busy
);
  import bsm_pkg::*;

  logic [2:0]           mode_q;
  logic                 restart, auto_en, enc_q, end_seen, dma_active;
  logic [NUM_BANKS-1:0] on_dma, release_v;

  assign restart = (mode != mode_q);
  assign auto_en = is_auto(mode_q);
  assign enc_q   = (mode_q == MODE_ENC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 3'd0;
    else        mode_q <= mode;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bsm_bank_ctrl u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .restart      (restart),
      .start_on_dma (mode == MODE_DEC),
      .auto_en      (auto_en),
      .fill_done    (fill_done[b]),
      .release_i    (release_v[b]),
      .on_dma       (on_dma[b])
    );
    always_comb begin
      if (auto_en) bank_owner[2*b +: 2] = on_dma[b] ? OWN_DMA : OWN_CODEC;
      else         bank_owner[2*b +: 2] = static_owner(mode_q, 1'(b));
    end
  end

  bsm_dma_seq #(.BANK_BYTES(BANK_BYTES), .MAX_XFER_BYTES(MAX_XFER_BYTES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (restart),
    .auto_en      (auto_en),
    .xfer_size    (xfer_size),
    .bank_on_dma  (on_dma),
    .req_ready    (dma_req_ready),
    .xfer_done    (dma_xfer_done),
    .req_valid    (dma_req_valid),
    .req_bank     (dma_req_bank),
    .req_bytes    (dma_req_bytes),
    .bank_release (release_v),
    .active       (dma_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      end_seen <= 1'b0;
    end else if (restart) begin
      busy     <= is_auto(mode);
      end_seen <= 1'b0;
    end else if (enc_q && busy) begin
      if (stream_end) end_seen <= 1'b1;
      if (end_seen && on_dma == '0 && !dma_active) busy <= 1'b0;
    end
  end

  // R2: static modes never show busy nor a request
  p_static_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |-> (!busy && !dma_req_valid));
  // R9: decode keeps busy set for as long as it lasts
  p_dec_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DEC) |-> busy);
endmodule

// File: tb/bsm_pingpong_mgr_tb_top.sv
module bsm_pingpong_mgr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [1:0]  xfer_size = 2'd0;
  logic [1:0]  fill_done = 2'b00;
  logic        stream_end = 1'b0;
  logic        dma_req_ready = 1'b0;
  logic        dma_xfer_done = 1'b0;
  logic [3:0]  bank_owner;
  logic        dma_req_valid, dma_req_bank, busy;
  logic [11:0] dma_req_bytes;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bsm_pingpong_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .xfer_size(xfer_size),
    .fill_done(fill_done), .stream_end(stream_end),
    .dma_req_ready(dma_req_ready), .dma_xfer_done(dma_xfer_done),
    .bank_owner(bank_owner), .dma_req_valid(dma_req_valid),
    .dma_req_bank(dma_req_bank), .dma_req_bytes(dma_req_bytes), .busy(busy)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // waits for a request, checks it, accepts it and completes the chunk
  task automatic do_chunk(input string tag, input logic bnk, input logic [11:0] bytes);
    int n = 0;
    while (!dma_req_valid && n < 10) begin step(); n++; end
    check({tag, " request raised"}, dma_req_valid, 1);
    check({tag, " request bank"}, dma_req_bank, bnk);
    check({tag, " request bytes"}, dma_req_bytes, bytes);
    dma_req_ready = 1'b1;
    step();
    dma_req_ready = 1'b0;
    check({tag, " request dropped after accept"}, dma_req_valid, 0);
    dma_xfer_done = 1'b1;
    step();
    dma_xfer_done = 1'b0;
  endtask

  task automatic pulse_fill(input logic [1:0] f);
    fill_done = f;
    step();
    fill_done = 2'b00;
  endtask

  // {mode, expected owners, expected busy}
  localparam logic [7:0] MODE_TBL [10] = '{
    {3'd0, 4'b0000, 1'b0}, {3'd3, 4'b1001, 1'b0}, {3'd1, 4'b0101, 1'b0},
    {3'd4, 4'b0110, 1'b0}, {3'd2, 4'b1010, 1'b0}, {3'd7, 4'b0000, 1'b0},
    {3'd5, 4'b1010, 1'b1}, {3'd2, 4'b1010, 1'b0}, {3'd6, 4'b0101, 1'b1},
    {3'd0, 4'b0000, 1'b0}
  };

  initial begin
    // reset state (R1, R2)
    step(); step();
    check("R1 owners in reset", bank_owner, 4'b0000);
    check("R2 busy in reset", busy, 0);
    rst_n = 1'b1;
    step();
    check("R1 owners after reset", bank_owner, 4'b0000);
    check("R2 no request after reset", dma_req_valid, 0);

    // mode table: R1 owner map, R2 quiet static modes, R3 auto entry
    for (int i = 0; i < 10; i++) begin
      mode = MODE_TBL[i][7:5];
      step();
      check("R1 owner map", bank_owner, MODE_TBL[i][4:1]);
      check("R3 busy per mode", busy, MODE_TBL[i][0]);
      if (!MODE_TBL[i][0]) check("R2 no request in static mode", dma_req_valid, 0);
    end

    // encode, 512-byte chunks (R3, R4, R5)
    mode = 3'd5; xfer_size = 2'd2;
    step();
    check("R3 encode starts codec-owned", bank_owner, 4'b1010);
    pulse_fill(2'b01);
    check("R4 bank0 handed to DMA", bank_owner[1:0], 2'd1);
    for (int c = 0; c < 4; c++) begin
      do_chunk("R5 enc bank0", 1'b0, 12'd512);
      if (c < 3) check("R5 bank0 held during chunks", bank_owner[1:0], 2'd1);
    end
    check("R5 bank0 returned after last chunk", bank_owner, 4'b1010);

    // R6: bank0 refilled out of turn gets no request
    pulse_fill(2'b01);
    step(); step();
    check("R6 out-of-turn bank not served", dma_req_valid, 0);
    pulse_fill(2'b10);
    do_chunk("R6 bank1 served first", 1'b1, 12'd512);
    xfer_size = 2'd0;  // R8: mid-bank change ignored
    for (int c = 0; c < 3; c++) do_chunk("R8 bank1 keeps size", 1'b1, 12'd512);
    check("R8 bank1 returned after 4 chunks", bank_owner[3:2], 2'd2);
    do_chunk("R8 bank0 new size", 1'b0, 12'd2048);
    check("R5 single chunk returns bank0", bank_owner, 4'b1010);

    // R7: back-pressure and stray done
    xfer_size = 2'd1;
    pulse_fill(2'b10);
    step();
    for (int k = 0; k < 3; k++) begin
      dma_xfer_done = (k == 1);
      step();
      check("R7 request held under back-pressure", dma_req_valid, 1);
      check("R7 bank stable under back-pressure", dma_req_bank, 1);
      check("R7 bytes stable under back-pressure", dma_req_bytes, 12'd1024);
    end
    dma_xfer_done = 1'b0;
    do_chunk("R7 bank1 chunk a", 1'b1, 12'd1024);
    check("R7 stray done not counted", bank_owner[3:2], 2'd1);
    do_chunk("R7 bank1 chunk b", 1'b1, 12'd1024);
    check("R7 bank1 returned", bank_owner[3:2], 2'd2);

    // R9: encode busy drains after stream end
    fill_done = 2'b01; stream_end = 1'b1;
    step();
    fill_done = 2'b00; stream_end = 1'b0;
    check("R9 busy held while bank on DMA side", busy, 1);
    do_chunk("R9 last bank a", 1'b0, 12'd1024);
    do_chunk("R9 last bank b", 1'b0, 12'd1024);
    check("R9 busy one cycle after flush", busy, 1);
    step();
    check("R9 busy cleared after flush", busy, 0);
    check("R9 no request after flush", dma_req_valid, 0);

    // R11: last-chunk done and codec hand-off in one cycle
    mode = 3'd0; step();
    mode = 3'd5; xfer_size = 2'd0; step();
    check("R3 encode re-entry busy", busy, 1);
    pulse_fill(2'b01);
    step();
    check("R11 bank0 request raised", dma_req_valid, 1);
    dma_req_ready = 1'b1; step(); dma_req_ready = 1'b0;
    dma_xfer_done = 1'b1; fill_done = 2'b10;
    step();
    dma_xfer_done = 1'b0; fill_done = 2'b00;
    check("R11 both hand-offs applied", bank_owner, 4'b0110);
    do_chunk("R11 bank1 next", 1'b1, 12'd2048);

    // decode (R3, R9, R10)
    mode = 3'd6; xfer_size = 2'd1;
    step();
    check("R3 decode starts DMA-owned", bank_owner, 4'b0101);
    check("R3 decode busy", busy, 1);
    do_chunk("R5 dec bank0 a", 1'b0, 12'd1024);
    do_chunk("R5 dec bank0 b", 1'b0, 12'd1024);
    check("R5 dec bank0 to codec", bank_owner, 4'b0110);
    step();
    check("R6 dec bank1 requested", dma_req_bank, 1);
    dma_req_ready = 1'b1; step(); dma_req_ready = 1'b0;
    mode = 3'd5;
    step();
    check("R10 owners reset on mode change", bank_owner, 4'b1010);
    check("R10 request cleared on mode change", dma_req_valid, 0);
    check("R9 busy on switch to encode", busy, 1);
    mode = 3'd6;
    step();
    check("R10 decode restart owners", bank_owner, 4'b0101);
    do_chunk("R10 pointer back at bank0", 1'b0, 12'd1024);
    check("R10 chunk count restarted", bank_owner[1:0], 2'd1);
    check("R9 decode busy holds", busy, 1);
    mode = 3'd2;
    step();
    check("R9 decode busy drops in static mode", busy, 0);
    check("R1 owners after leaving decode", bank_owner, 4'b1010);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule